// File: doc/BRIEF.md
# Multi-Channel DMA Status and Command Registers

This block is the control and status register file for a DMA controller with up to 64 channels. It keeps five bits for each channel: request enable, error-interrupt enable, interrupt pending, error pending and done. A plain register bus reads and writes them as 32-bit words. Channels 31..0 sit in a low word and channels 63..32 in a high word. The transfer engines report completion and faults through per-channel event inputs. The block turns these into pending bits, a single interrupt line and a captured error report.

Software can change one channel's bit without a read-modify-write. It writes the channel number to a command port, and each command port acts on one bank of bits. Pending words are also write-one-to-clear. An error status word keeps the first fault: its channel and its cause bits. It releases that content once software has cleared that channel's error-pending bit. A build parameter reduces the channel count, for example to 16, and the high words then read as zero.

Top module: `dma_chan_csr`

Bus word addresses (`addr_i`):
- 0/1: request enable low/high
- 2/3: error-interrupt enable low/high
- 4/5: interrupt pending low/high
- 6/7: error pending low/high
- 8/9: done low/high
- 10: error status
- 16..23 (command ports): set request, clear request, set error-interrupt enable, clear error-interrupt enable, clear interrupt, clear error, start, clear done

## Requirements
- R1: After reset every bit bank, the error status word, `irq_o`, `start_o` and `req_en_o` are zero.
- R2: Channel i appears at bit i of the low word (addresses 0, 2, 4, 6, 8) for i < 32, and at bit i-32 of the high word (addresses 1, 3, 5, 7, 9) for i ≥ 32. Writing address 0/1 or 2/3 loads the whole enable word, and `req_en_o` mirrors the request-enable bits.
- R3: A write of channel number N in `wdata_i[7:0]` to address 16, 17, 18 or 19 sets or clears only bit N of the request-enable or error-interrupt-enable bank. Values of N at or above the channel count change nothing.
- R4: A write of channel N to address 20, 21 or 23 clears only channel N's interrupt-pending, error-pending or done bit. The done words (8/9) ignore word writes.
- R5: Writing to an interrupt-pending or error-pending word clears each bit written as one and leaves bits written as zero. All ones clears the whole word.
- R6: `done_ev_i[i]` sets interrupt pending and done for channel i, and `err_ev_i[i]` sets error pending. An event overrides a clear aimed at the same bit in the same cycle.
- R7: Error status word layout: bit 31 is valid, bits 13:8 hold the channel, bits 15:14 hold `err_cause_i[15:14]` and bits 7:0 hold `err_cause_i[7:0]`. All other bits read zero. When several channels fault in one cycle, the lowest-numbered one is logged.
- R8: While the valid bit is set, new error events do not change the error status word.
- R9: The error status word returns to zero one cycle after the logged channel's error-pending bit reads clear.
- R10: `irq_o` is high exactly when some interrupt-pending bit is set, or some error-pending bit is set together with that channel's error-interrupt enable.
- R11: A write of channel N to address 22 raises only `start_o[N]`, for the single cycle that follows the write.
- R12: Command ports (16..23) and unmapped addresses read zero.
- R13: With 16 channels, the high words read zero, high-word writes have no effect, and channel numbers 16 and above are ignored by command ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 5 | Register word address |
| wdata_i | input | 32 | Write data; command ports take the channel number in bits 7:0 |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| done_ev_i | input | NUM_CH | Per-channel completion events |
| err_ev_i | input | NUM_CH | Per-channel error events |
| err_cause_i | input | 16 | Cause bits that go with the error events |
| req_en_o | output | NUM_CH | Request-enable bits to the engines |
| start_o | output | NUM_CH | One-cycle start strobes |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check four things on every cycle:
- An enabled error or pending interrupt always drives `irq_o`.
- Start strobes are at most one-hot and only follow a start-port write.
- A valid error status never changes, and its channel field stays within range.
- An error event always leaves some error-pending bit set.

Other behaviours show only in the bench's scenarios:
- Which channel wins a simultaneous fault, and which cause bits the status word keeps.
- The one-cycle delay before the status releases.
- An event winning over a same-cycle clear.
- Write-one-to-clear leaving zero-written bits alone.
- The reduced 16-channel build ignoring high words and out-of-range channel numbers.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int MAX_CH   = 64;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int CH_IDX_W = 6;
    localparam int CAUSE_W  = 16;

    typedef enum logic [ADDR_W-1:0] {
        A_REQ_LO    = 5'd0,
        A_REQ_HI    = 5'd1,
        A_EIE_LO    = 5'd2,
        A_EIE_HI    = 5'd3,
        A_INT_LO    = 5'd4,
        A_INT_HI    = 5'd5,
        A_ERR_LO    = 5'd6,
        A_ERR_HI    = 5'd7,
        A_DONE_LO   = 5'd8,
        A_DONE_HI   = 5'd9,
        A_ESTAT     = 5'd10,
        A_SET_REQ   = 5'd16,
        A_CLR_REQ   = 5'd17,
        A_SET_EIE   = 5'd18,
        A_CLR_EIE   = 5'd19,
        A_CLR_INT   = 5'd20,
        A_CLR_ERR   = 5'd21,
        A_SET_START = 5'd22,
        A_CLR_DONE  = 5'd23
    } csr_addr_e;

    // How a bank reacts to a full-word write
    typedef enum logic [1:0] {
        BK_RW  = 2'd0,   // word write loads the bits
        BK_W1C = 2'd1,   // ones in the write data clear bits
        BK_RO  = 2'd2    // word writes ignored
    } bank_mode_e;

    typedef struct packed {
        logic        valid;
        logic [14:0] rsvd;
        logic [1:0]  prio_cause;
        logic [5:0]  chan;
        logic [7:0]  xfer_cause;
    } err_stat_t;

    typedef struct packed {
        logic set_req;
        logic clr_req;
        logic set_eie;
        logic clr_eie;
        logic clr_int;
        logic clr_err;
        logic set_start;
        logic clr_done;
    } cmd_t;

    function automatic logic [WORD_W-1:0] pick_word(input logic [MAX_CH-1:0] v,
                                                    input logic hi);
        return hi ? v[MAX_CH-1:WORD_W] : v[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/dma_bit_bank.sv
module dma_bit_bank
    import dma_csr_pkg::*;
#(
    parameter int         N    = 64,
    parameter bank_mode_e MODE = BK_RW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                cmd_set,
    input  logic                cmd_clr,
    input  logic [CH_IDX_W-1:0] cmd_ch,
    input  logic [N-1:0]        ev_set,
    output logic [N-1:0]        bits_o
);

    logic [N-1:0] q;
    logic [N-1:0] d;

    // Precedence: word write, then command clear, then command set, then event
    always_comb begin
        d = q;
        for (int i = 0; i < N; i++) begin
            if ((i >= WORD_W) ? wr_hi : wr_lo) begin
                if (MODE == BK_RW) begin
                    d[i] = wdata[i % WORD_W];
                end else if (MODE == BK_W1C) begin
                    if (wdata[i % WORD_W]) d[i] = 1'b0;
                end
            end
            if (cmd_clr && (cmd_ch == CH_IDX_W'(i))) d[i] = 1'b0;
            if (cmd_set && (cmd_ch == CH_IDX_W'(i))) d[i] = 1'b1;
            if (ev_set[i]) d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign bits_o = q;

    logic unused_inputs;
    assign unused_inputs = ^{wr_hi, wdata};

endmodule

// File: rtl/dma_err_log.sv
module dma_err_log
    import dma_csr_pkg::*;
#(
    parameter int N = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       err_ev,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [N-1:0]       errp,
    output err_stat_t          stat_o
);

    err_stat_t            stat_q;
    logic                 found;
    logic [CH_IDX_W-1:0]  first_ch;
    logic                 logged_pending;

    // Lowest-numbered faulting channel wins
    always_comb begin
        found    = 1'b0;
        first_ch = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (err_ev[i]) begin
                found    = 1'b1;
                first_ch = CH_IDX_W'(i);
            end
        end
    end

    always_comb begin
        logged_pending = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (stat_q.chan == CH_IDX_W'(i)) logged_pending = errp[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else if (stat_q.valid) begin
            if (!logged_pending) stat_q <= '0;
        end else if (found) begin
            stat_q.valid      <= 1'b1;
            stat_q.rsvd       <= '0;
            stat_q.prio_cause <= cause[15:14];
            stat_q.chan       <= first_ch;
            stat_q.xfer_cause <= cause[7:0];
        end
    end

    assign stat_o = stat_q;

    logic unused_cause;
    assign unused_cause = ^cause[13:8];

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
    import dma_csr_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [WORD_W-1:0]  wdata_i,
    input  logic               we_i,
    output logic [WORD_W-1:0]  rdata_o,
    input  logic [NUM_CH-1:0]  done_ev_i,
    input  logic [NUM_CH-1:0]  err_ev_i,
    input  logic [CAUSE_W-1:0] err_cause_i,
    output logic [NUM_CH-1:0]  req_en_o,
    output logic [NUM_CH-1:0]  start_o,
    output logic               irq_o
);

    localparam int HAS_HI = (NUM_CH > WORD_W) ? 1 : 0;

    cmd_t                cmd;
    logic                ch_ok;
    logic [CH_IDX_W-1:0] cmd_ch;

    assign cmd_ch = wdata_i[CH_IDX_W-1:0];
    assign ch_ok  = (wdata_i[7:0] < 8'(NUM_CH));

    always_comb begin
        cmd           = '0;
        cmd.set_req   = we_i && ch_ok && (addr_i == A_SET_REQ);
        cmd.clr_req   = we_i && ch_ok && (addr_i == A_CLR_REQ);
        cmd.set_eie   = we_i && ch_ok && (addr_i == A_SET_EIE);
        cmd.clr_eie   = we_i && ch_ok && (addr_i == A_CLR_EIE);
        cmd.clr_int   = we_i && ch_ok && (addr_i == A_CLR_INT);
        cmd.clr_err   = we_i && ch_ok && (addr_i == A_CLR_ERR);
        cmd.set_start = we_i && ch_ok && (addr_i == A_SET_START);
        cmd.clr_done  = we_i && ch_ok && (addr_i == A_CLR_DONE);
    end

    logic [NUM_CH-1:0] req_q, eie_q, int_q, err_q, done_q;
    logic [NUM_CH-1:0] start_q;
    err_stat_t         err_stat;

    dma_bit_bank #(.N(NUM_CH), .MODE(BK_RW)) u_req_bank (
        .clk(clk), .rst(rst),
        .wr_lo(we_i && addr_i == A_REQ_LO), .wr_hi(we_i && addr_i == A_REQ_HI),
        .wdata(wdata_i), .cmd_set(cmd.set_req), .cmd_clr(cmd.clr_req),
        .cmd_ch(cmd_ch), .ev_set('0), .bits_o(req_q)
    );

    dma_bit_bank #(.N(NUM_CH), .MODE(BK_RW)) u_eie_bank (
        .clk(clk), .rst(rst),
        .wr_lo(we_i && addr_i == A_EIE_LO), .wr_hi(we_i && addr_i == A_EIE_HI),
        .wdata(wdata_i), .cmd_set(cmd.set_eie), .cmd_clr(cmd.clr_eie),
        .cmd_ch(cmd_ch), .ev_set('0), .bits_o(eie_q)
    );

    dma_bit_bank #(.N(NUM_CH), .MODE(BK_W1C)) u_int_bank (
        .clk(clk), .rst(rst),
        .wr_lo(we_i && addr_i == A_INT_LO), .wr_hi(we_i && addr_i == A_INT_HI),
        .wdata(wdata_i), .cmd_set(1'b0), .cmd_clr(cmd.clr_int),
        .cmd_ch(cmd_ch), .ev_set(done_ev_i), .bits_o(int_q)
    );

    dma_bit_bank #(.N(NUM_CH), .MODE(BK_W1C)) u_err_bank (
        .clk(clk), .rst(rst),
        .wr_lo(we_i && addr_i == A_ERR_LO), .wr_hi(we_i && addr_i == A_ERR_HI),
        .wdata(wdata_i), .cmd_set(1'b0), .cmd_clr(cmd.clr_err),
        .cmd_ch(cmd_ch), .ev_set(err_ev_i), .bits_o(err_q)
    );

    dma_bit_bank #(.N(NUM_CH), .MODE(BK_RO)) u_done_bank (
        .clk(clk), .rst(rst),
        .wr_lo(1'b0), .wr_hi(1'b0),
        .wdata(wdata_i), .cmd_set(1'b0), .cmd_clr(cmd.clr_done),
        .cmd_ch(cmd_ch), .ev_set(done_ev_i), .bits_o(done_q)
    );

    dma_err_log #(.N(NUM_CH)) u_err_log (
        .clk(clk), .rst(rst),
        .err_ev(err_ev_i), .cause(err_cause_i),
        .errp(err_q), .stat_o(err_stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                start_q[i] <= cmd.set_start && (cmd_ch == CH_IDX_W'(i));
            end
        end
    end

    // Read path over zero-extended banks; absent high words read zero
    logic [MAX_CH-1:0] req_x, eie_x, int_x, err_x, done_x;
    logic              hi_sel;

    assign req_x  = MAX_CH'(req_q);
    assign eie_x  = MAX_CH'(eie_q);
    assign int_x  = MAX_CH'(int_q);
    assign err_x  = MAX_CH'(err_q);
    assign done_x = MAX_CH'(done_q);
    assign hi_sel = addr_i[0] && (HAS_HI != 0);

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_REQ_LO,  A_REQ_HI:  rdata_o = pick_word(req_x, hi_sel);
            A_EIE_LO,  A_EIE_HI:  rdata_o = pick_word(eie_x, hi_sel);
            A_INT_LO,  A_INT_HI:  rdata_o = pick_word(int_x, hi_sel);
            A_ERR_LO,  A_ERR_HI:  rdata_o = pick_word(err_x, hi_sel);
            A_DONE_LO, A_DONE_HI: rdata_o = pick_word(done_x, hi_sel);
            A_ESTAT:              rdata_o = err_stat;
            default:              rdata_o = '0;
        endcase
        if (addr_i[0] && (HAS_HI == 0)) rdata_o = '0;
    end

    assign req_en_o = req_q;
    assign start_o  = start_q;
    assign irq_o    = (|int_q) | (|(err_q & eie_q));

endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk
    import dma_csr_pkg::*;
#(
    parameter int N = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_o,
    input logic [N-1:0]      start_o,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input err_stat_t         stat,
    input logic [N-1:0]      intp,
    input logic [N-1:0]      errp,
    input logic [N-1:0]      eie,
    input logic [N-1:0]      err_ev
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!irq_o && (start_o == '0) && (stat == '0)));

    p_err_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (|(errp & eie)) |-> irq_o);

    p_int_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (|intp) |-> irq_o);

    p_start_src_r11: assert property (@(posedge clk) disable iff (rst)
        (|start_o) |-> $past(we_i && (addr_i == A_SET_START)));

    p_start_one_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_o));

    p_stat_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (stat.valid && $past(stat.valid)) |-> $stable(stat));

    p_stat_chan_r7: assert property (@(posedge clk) disable iff (rst)
        stat.valid |-> (32'(stat.chan) < N));

    p_err_set_r6: assert property (@(posedge clk) disable iff (rst)
        (|err_ev) |=> (|errp));

endmodule

bind dma_chan_csr dma_chan_csr_chk #(.N(NUM_CH)) u_chk (
    .clk(clk), .rst(rst), .irq_o(irq_o), .start_o(start_o),
    .we_i(we_i), .addr_i(addr_i), .stat(err_stat),
    .intp(int_q), .errp(err_q), .eie(eie_q), .err_ev(err_ev_i)
);

// File: tb/test_dma_chan_csr.sv
`timescale 1ns/1ps
module test_dma_chan_csr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [63:0] dev = '0;
    logic [63:0] eev = '0;
    logic [15:0] cause = '0;
    logic [31:0] rdata;
    logic [63:0] req_en, start;
    logic        irq;

    logic [31:0] rdata_s;
    logic [15:0] req_s, start_s;
    logic        irq_s;

    always #10 clk = ~clk;   // 50 MHz

    dma_chan_csr #(.NUM_CH(64)) i_dma_chan_csr (
        .clk(clk), .rst(rst), .addr_i(addr), .wdata_i(wdata), .we_i(we),
        .rdata_o(rdata), .done_ev_i(dev), .err_ev_i(eev), .err_cause_i(cause),
        .req_en_o(req_en), .start_o(start), .irq_o(irq)
    );

    dma_chan_csr #(.NUM_CH(16)) i_dma_chan_csr_r16 (
        .clk(clk), .rst(rst), .addr_i(addr), .wdata_i(wdata), .we_i(we),
        .rdata_o(rdata_s), .done_ev_i(16'h0), .err_ev_i(16'h0), .err_cause_i(16'h0),
        .req_en_o(req_s), .start_o(start_s), .irq_o(irq_s)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference state, 64-channel build
    bit [63:0] m_req, m_eie, m_int, m_err, m_done, m_start;
    bit        m_v;
    bit [5:0]  m_ch;
    bit [15:0] m_cause;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] exp_stat();
        return {m_v, 15'b0, m_cause[15:14], m_ch, m_cause[7:0]};
    endfunction

    function automatic bit [31:0] exp_read(input bit [4:0] a);
        case (a)
            5'd0: return m_req[31:0];   5'd1: return m_req[63:32];
            5'd2: return m_eie[31:0];   5'd3: return m_eie[63:32];
            5'd4: return m_int[31:0];   5'd5: return m_int[63:32];
            5'd6: return m_err[31:0];   5'd7: return m_err[63:32];
            5'd8: return m_done[31:0];  5'd9: return m_done[63:32];
            5'd10: return exp_stat();
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input bit [4:0] a);
        if (a <= 5'd3) return "R2 enable word";
        if (a <= 5'd7) return "R5 pending word";
        if (a <= 5'd9) return "R4 done word";
        if (a == 5'd10) return "R7 status word";
        return "R12 zero read";
    endfunction

    task automatic model_step(input bit w, input bit [4:0] a, input bit [31:0] d,
                              input bit [63:0] de, input bit [63:0] ee, input bit [15:0] ca);
        bit [63:0] nreq = m_req, neie = m_eie, nint = m_int, nerr = m_err, ndone = m_done;
        bit ok = (d[7:0] < 8'd64);
        bit [5:0] c = d[5:0];
        m_start = '0;
        if (w) begin
            case (a)
                5'd0: nreq[31:0] = d;   5'd1: nreq[63:32] = d;
                5'd2: neie[31:0] = d;   5'd3: neie[63:32] = d;
                5'd4: nint[31:0] &= ~d; 5'd5: nint[63:32] &= ~d;
                5'd6: nerr[31:0] &= ~d; 5'd7: nerr[63:32] &= ~d;
                5'd16: if (ok) nreq[c] = 1'b1;
                5'd17: if (ok) nreq[c] = 1'b0;
                5'd18: if (ok) neie[c] = 1'b1;
                5'd19: if (ok) neie[c] = 1'b0;
                5'd20: if (ok) nint[c] = 1'b0;
                5'd21: if (ok) nerr[c] = 1'b0;
                5'd22: if (ok) m_start[c] = 1'b1;
                5'd23: if (ok) ndone[c] = 1'b0;
                default: ;
            endcase
        end
        nint  |= de;
        ndone |= de;
        nerr  |= ee;
        if (m_v) begin
            if (!m_err[m_ch]) begin m_v = 0; m_ch = 0; m_cause = 0; end
        end else if (ee != 0) begin
            for (int i = 63; i >= 0; i--) if (ee[i]) m_ch = 6'(i);
            m_v = 1;
            m_cause = ca & 16'hC0FF;
        end
        m_req = nreq; m_eie = neie; m_int = nint; m_err = nerr; m_done = ndone;
    endtask

    task automatic check_outs();
        chk("R3 req_en_o", req_en, m_req);
        chk("R11 start_o", start, m_start);
        chk("R10 irq_o", irq, |m_int | |(m_err & m_eie));
    endtask

    task automatic step(input bit w, input bit [4:0] a, input bit [31:0] d,
                        input bit [63:0] de, input bit [63:0] ee, input bit [15:0] ca);
        @(negedge clk);
        we = w; addr = a; wdata = d; dev = de; eev = ee; cause = ca;
        @(posedge clk);
        model_step(w, a, d, de, ee, ca);
        #2;
        check_outs();
    endtask

    // one idle cycle; every address read in its low phase
    task automatic read_all();
        @(negedge clk);
        we = 0; dev = '0; eev = '0; cause = '0;
        for (int a = 0; a < 32; a++) begin
            addr = 5'(a);
            #0.2;
            chk(tag_of(5'(a)), rdata, exp_read(5'(a)));
        end
        @(posedge clk);
        model_step(0, addr, wdata, '0, '0, '0);
        #2;
        check_outs();
    endtask

    task automatic peek(input bit [4:0] a, output logic [31:0] v);
        addr = a;
        #0.2;
        v = rdata;
    endtask

    task automatic peek_s(input bit [4:0] a, output logic [31:0] v);
        addr = a;
        #0.2;
        v = rdata_s;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk("R1 irq_o", irq, 0);
        chk("R1 start_o", start, 0);
        chk("R1 req_en_o", req_en, 0);
        read_all();

        // R13: reduced 16-channel build
        step(1, 5'd1, 32'hFFFF_FFFF, '0, '0, '0);
        step(1, 5'd16, 32'd20, '0, '0, '0);
        step(1, 5'd16, 32'd5, '0, '0, '0);
        peek_s(5'd1, v);  chk("R13 high word reads zero", v, 0);
        peek_s(5'd0, v);  chk("R13 low word", v, 32'h20);
        chk("R13 req_en_s", req_s, 16'h0020);
        step(1, 5'd22, 32'd17, '0, '0, '0);
        chk("R13 start_s ignored", start_s, 0);
        step(1, 5'd22, 32'd3, '0, '0, '0);
        chk("R13 start_s", start_s, 16'h0008);

        // R3: only channel 37 affected; out-of-range number ignored
        step(1, 5'd0, 32'h0, '0, '0, '0);
        step(1, 5'd1, 32'h0, '0, '0, '0);
        step(1, 5'd16, 32'd37, '0, '0, '0);
        chk("R3 set ch37", req_en, 64'h1 << 37);
        step(1, 5'd16, 32'd64, '0, '0, '0);
        chk("R3 ch64 ignored", req_en, 64'h1 << 37);
        step(1, 5'd17, 32'd37, '0, '0, '0);
        chk("R3 clr ch37", req_en, 0);

        // R11: start pulse lasts one cycle
        step(1, 5'd22, 32'd9, '0, '0, '0);
        chk("R11 start pulse", start, 64'h1 << 9);
        step(0, 5'd0, 0, '0, '0, '0);
        chk("R11 start ends", start, 0);

        // R7: two channels fault together; cause bits 13:8 dropped
        step(0, 5'd0, 0, '0, (64'h1 << 40) | (64'h1 << 41), 16'h3F21);
        peek(5'd10, v); chk("R7 status capture", v, 32'h8000_2821);
        // R8: later fault does not overwrite
        step(0, 5'd0, 0, '0, 64'h4, 16'hC0FF);
        peek(5'd10, v); chk("R8 status held", v, 32'h8000_2821);
        // R10: enabled error raises irq
        step(1, 5'd18, 32'd41, '0, '0, '0);
        chk("R10 irq from enabled error", irq, 1);
        // R9: release one cycle after clear
        step(1, 5'd21, 32'd40, '0, '0, '0);
        peek(5'd10, v); chk("R9 still valid", v, 32'h8000_2821);
        step(0, 5'd0, 0, '0, '0, '0);
        peek(5'd10, v); chk("R9 released", v, 0);
        peek(5'd7, v);  chk("R4 only ch40 cleared", v, 32'h0000_0200);

        // R6: event beats same-cycle clear
        step(1, 5'd21, 32'd3, '0, 64'h8, 16'h0001);
        peek(5'd6, v);  chk("R6 event wins", v[3], 1);

        // R5: zeros leave bits, ones clear
        step(0, 5'd0, 0, 64'hF0, '0, '0);
        step(1, 5'd4, 32'h0, '0, '0, '0);
        peek(5'd4, v);  chk("R5 zero write keeps", v, 32'hF0);
        step(1, 5'd4, 32'h30, '0, '0, '0);
        peek(5'd4, v);  chk("R5 partial clear", v, 32'hC0);
        step(1, 5'd8, 32'hFFFF_FFFF, '0, '0, '0);
        peek(5'd8, v);  chk("R4 done ignores word write", v, 32'hF0);
        step(1, 5'd23, 32'd5, '0, '0, '0);
        peek(5'd8, v);  chk("R4 clear done ch5", v, 32'hD0);
        read_all();

        // constrained random traffic
        for (int k = 0; k < 1500; k++) begin
            int op = $urandom % 10;
            bit [4:0] a;
            bit [31:0] d;
            bit [63:0] de = '0, ee = '0;
            if (op < 6) begin
                a = 5'($urandom % 24);
                d = (a >= 5'd16) ? ($urandom % 80) : $urandom;
            end else begin
                a = 5'd0; d = 0;
            end
            if ($urandom % 4 == 0)
                de = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            if ($urandom % 8 == 0) begin
                ee[$urandom % 64] = 1'b1;
                if ($urandom % 2 == 0) ee[$urandom % 64] = 1'b1;
            end
            step(op < 6, a, d, de, ee, 16'($urandom));
            if (k % 16 == 15) read_all();
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule